// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is a synchronous host-side controller for a 12-bit converter whose result is read over a shared 8-bit parallel bus. When a start request arrives while the sequencer is idle, it pulls the converter's read/convert strobe low. It keeps the strobe low until the converter's status line has risen and fallen again. It then releases the strobe, waits for the bus drivers to leave high impedance, and reads the result as two bytes.

A select output picks which part of the result the converter presents. The upper byte is read first and the lower nibble second. Each byte is sampled only after its own settle delay has elapsed. The assembled 12-bit word appears on the data output with a single-cycle valid pulse.

Every minimum delay and timeout is a parameter counted in system clock cycles, rounded up from the converter's nanosecond figures. The status input crosses into the clock domain through a two-flop synchroniser. If status fails to rise, or fails to fall, within its timeout, the block pulses an error output and returns to idle.

Top module: `pbus_adc_seq`

## Requirements
- R1: After reset, rc_no is 1, sel_o is 0, valid_o is 0 and err_o is 0.
- R2: A start_i sampled high while idle drives rc_no low from the next cycle. rc_no then stays low for at least LowCycles cycles.
- R3: rc_no stays low until status_i has been seen high and then low through the two-flop synchroniser. After that, rc_no returns to 1.
- R4: sel_o changes only while rc_no is 1. After rc_no rises, BusSettle cycles pass before sel_o goes to 1, which selects the upper byte. The bus is sampled after sel_o has been 1 for SelSettle cycles. sel_o then returns to 0, which selects the lower part, and the bus is sampled again after SelSettle more cycles.
- R5: The upper-byte sample forms data_o[11:4]. Bits [7:4] of the lower-byte sample form data_o[3:0]. Bits [3:0] of the lower-byte sample have no effect.
- R6: valid_o is a single-cycle pulse carrying the assembled word on data_o.
- R7: A start_i that arrives while a sequence is in progress is ignored. It produces no second conversion and no second valid_o.
- R8: If status_i is not seen high within RiseTimeout cycles after the minimum low time, err_o pulses for one cycle, rc_no returns to 1, and no valid_o is produced.
- R9: If status_i is not seen low within ConvTimeout cycles after it rose, err_o pulses for one cycle, rc_no returns to 1, and no valid_o is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only while idle |
| status_i | input | 1 | Converter busy status, asynchronous |
| bus_i | input | 8 | Converter parallel data bus |
| rc_no | output | 1 | Read/convert strobe, low starts and holds a conversion |
| sel_o | output | 1 | Byte select, 1 upper byte, 0 lower nibble |
| data_o | output | 12 | Assembled conversion result |
| valid_o | output | 1 | One-cycle pulse when data_o is new |
| err_o | output | 1 | One-cycle pulse on a status timeout |

## Verification
The assertions assume that start_i is synchronous to clk_i. They also assume that the converter raises status_i only after the strobe falls and drops it before the strobe is released, so the synchroniser latency never shows a stale level at the start of a new conversion. The bench converter model follows these assumptions. It drives status from a counter of cycles since the strobe fell. Between conversions the bench waits long enough for the synchronised status to clear. The model puts junk on the bus whenever the strobe or the select line changed fewer than four cycles earlier, so a sample taken before the settle delay returns a wrong word.

// File: rtl/pbus_adc_pkg.sv
package pbus_adc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_WHI,
    S_WLO,
    S_SETL,
    S_SELH,
    S_SELL
  } seq_state_e;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int unsigned Width = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);
  logic [Width-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/adc_dly_tmr.sv
module adc_dly_tmr #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [Width-1:0] val_i,
  output logic             done_o
);
  logic [Width-1:0] cnt_q;

  // a load of N makes done_o high in the N-th cycle after the load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i - Width'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - Width'(1);
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_adc_seq.sv
module pbus_adc_seq #(
  parameter int unsigned LowCycles   = 5,
  parameter int unsigned RiseTimeout = 40,
  parameter int unsigned ConvTimeout = 200,
  parameter int unsigned BusSettle   = 5,
  parameter int unsigned SelSettle   = 5,
  parameter int unsigned ResW        = 12,
  parameter int unsigned BusW        = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            status_i,
  input  logic [BusW-1:0] bus_i,
  output logic            rc_no,
  output logic            sel_o,
  output logic [ResW-1:0] data_o,
  output logic            valid_o,
  output logic            err_o
);
  import pbus_adc_pkg::*;

  localparam int unsigned LoW   = ResW - BusW;
  localparam int unsigned SumT  = LowCycles + RiseTimeout + ConvTimeout + BusSettle + SelSettle;
  localparam int unsigned TmrW  = $clog2(SumT + 1) + 1;

  seq_state_e      state_q, state_d;
  logic            stat_s;
  logic            tmr_ld, tmr_done;
  logic [TmrW-1:0] tmr_val;
  logic            err_set, samp_hi, samp_lo;
  logic [BusW-1:0] hi_q;
  logic [ResW-1:0] data_q;
  logic            valid_q, err_q;

  adc_sync2 #(.Width(1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (status_i),
    .q_o    (stat_s)
  );

  adc_dly_tmr #(.Width(TmrW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    err_set = 1'b0;
    samp_hi = 1'b0;
    samp_lo = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_LOW;
        tmr_ld  = 1'b1;
        tmr_val = TmrW'(LowCycles);
      end
      S_LOW: if (tmr_done) begin
        state_d = S_WHI;
        tmr_ld  = 1'b1;
        tmr_val = TmrW'(RiseTimeout);
      end
      S_WHI: begin
        if (stat_s) begin
          state_d = S_WLO;
          tmr_ld  = 1'b1;
          tmr_val = TmrW'(ConvTimeout);
        end else if (tmr_done) begin
          state_d = S_IDLE;
          err_set = 1'b1;
        end
      end
      S_WLO: begin
        if (!stat_s) begin
          state_d = S_SETL;
          tmr_ld  = 1'b1;
          tmr_val = TmrW'(BusSettle);
        end else if (tmr_done) begin
          state_d = S_IDLE;
          err_set = 1'b1;
        end
      end
      S_SETL: if (tmr_done) begin
        state_d = S_SELH;
        tmr_ld  = 1'b1;
        tmr_val = TmrW'(SelSettle);
      end
      S_SELH: if (tmr_done) begin
        state_d = S_SELL;
        samp_hi = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = TmrW'(SelSettle);
      end
      S_SELL: if (tmr_done) begin
        state_d = S_IDLE;
        samp_lo = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hi_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= samp_lo;
      err_q   <= err_set;
      if (samp_hi) hi_q <= bus_i;
      if (samp_lo) data_q <= {hi_q, bus_i[BusW-1 -: LoW]};
    end
  end

  assign rc_no   = !(state_q inside {S_LOW, S_WHI, S_WLO});
  assign sel_o   = (state_q == S_SELH);
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pbus_adc_seq_chk.sv
module pbus_adc_seq_chk #(
  parameter int unsigned LowCycles = 5,
  parameter int unsigned SelSettle = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rc_no,
  input logic sel_o,
  input logic valid_o,
  input logic err_o
);
  logic [15:0] low_cnt, sel_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      sel_cnt <= '0;
    end else begin
      low_cnt <= rc_no ? '0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1);
      sel_cnt <= !sel_o ? '0 : ((sel_cnt == 16'hFFFF) ? sel_cnt : sel_cnt + 16'd1);
    end
  end

  assert_rc_min_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rc_no) |-> (low_cnt >= 16'(LowCycles)));

  assert_sel_rc_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> rc_no);

  assert_sel_settle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> (sel_cnt >= 16'(SelSettle)));

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_start_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rc_no) |-> $past(start_i));

  assert_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

bind pbus_adc_seq pbus_adc_seq_chk #(
  .LowCycles (LowCycles),
  .SelSettle (SelSettle)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .rc_no   (rc_no),
  .sel_o   (sel_o),
  .valid_o (valid_o),
  .err_o   (err_o)
);

// File: tb/test_pbus_adc_seq.sv
module test_pbus_adc_seq;
  localparam int Lat  = 4;
  localparam int Rise = 3;
  localparam int Conv = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        status = 1'b0;
  logic [7:0]  bus = 8'h00;
  logic        rc_n, sel, valid, err;
  logic [11:0] data;

  int tests = 0;
  int fails = 0;
  int val_seen = 0;
  int err_seen = 0;
  int mode = 0;  // 0 normal, 1 no status rise, 2 status stuck high
  logic [11:0] conv_word = '0;
  logic [3:0]  junk_nib = 4'h0;
  logic [11:0] exp_q[$];
  int low_age = 0, hi_age = 0, sel_age = 0, last_low = 0;
  logic prev_sel = 1'b0;

  always #4 clk = ~clk;

  pbus_adc_seq #(
    .LowCycles(5), .RiseTimeout(20), .ConvTimeout(100),
    .BusSettle(5), .SelSettle(5), .ResW(12), .BusW(8)
  ) i_pbus_adc_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_i(status),
    .bus_i(bus), .rc_no(rc_n), .sel_o(sel), .data_o(data),
    .valid_o(valid), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rc_n) begin
      low_age = low_age + 1;
      hi_age  = 0;
    end else begin
      if (low_age != 0) last_low = low_age;
      low_age = 0;
      hi_age  = hi_age + 1;
    end
    if (sel != prev_sel) sel_age = 0; else sel_age = sel_age + 1;
    prev_sel = sel;
    case (mode)
      0: status = !rc_n && low_age >= Rise && low_age < Rise + Conv;
      1: status = 1'b0;
      default: status = !rc_n && low_age >= Rise;
    endcase
    if (rc_n && hi_age >= Lat && sel_age >= Lat)
      bus = sel ? conv_word[11:4] : {conv_word[3:0], junk_nib};
    else
      bus = 8'hE7;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      val_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid", int'(data), 0);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        check(data == e, "R4 R5 R6 data", int'(data), int'(e));
      end
    end
    if (rst_n && err) err_seen++;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_conv(input logic [11:0] w, input logic [3:0] jn, input bit ok);
    int v0, e0;
    v0 = val_seen;
    e0 = err_seen;
    conv_word = w;
    junk_nib  = jn;
    if (ok) exp_q.push_back(w);
    pulse_start();
    check(rc_n == 1'b0, "R2 strobe low after start", int'(rc_n), 0);
    while (val_seen == v0 && err_seen == e0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int v0, e0;
    repeat (3) @(negedge clk);
    check(rc_n == 1'b1 && sel == 1'b0, "R1 reset strobe/select", int'({rc_n, sel}), 2);
    check(valid == 1'b0 && err == 1'b0, "R1 reset valid/err", int'({valid, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_conv(12'hA5C, 4'h3, 1'b1);
    check(last_low >= Rise + Conv, "R3 strobe held through conversion", last_low, Rise + Conv);
    check(rc_n == 1'b1, "R3 strobe released", int'(rc_n), 1);
    run_conv(12'h000, 4'hF, 1'b1);
    run_conv(12'hFFF, 4'h0, 1'b1);
    run_conv(12'h801, 4'hA, 1'b1);
    run_conv(12'h37E, 4'h5, 1'b1);

    // R7: start during conversion
    v0 = val_seen;
    conv_word = 12'h6B2;
    junk_nib  = 4'h9;
    exp_q.push_back(12'h6B2);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (150) @(negedge clk);
    check(val_seen == v0 + 1, "R7 start while busy ignored", val_seen - v0, 1);

    // R8: status never rises
    mode = 1;
    e0 = err_seen;
    run_conv(12'h111, 4'h0, 1'b0);
    check(err_seen == e0 + 1, "R8 rise timeout error", err_seen - e0, 1);
    check(rc_n == 1'b1, "R8 strobe released", int'(rc_n), 1);

    // R9: status stuck high
    mode = 2;
    e0 = err_seen;
    run_conv(12'h222, 4'h0, 1'b0);
    check(err_seen == e0 + 1, "R9 conversion timeout error", err_seen - e0, 1);
    check(rc_n == 1'b1, "R9 strobe released", int'(rc_n), 1);

    mode = 0;
    repeat (10) @(negedge clk);
    run_conv(12'hC3D, 4'h6, 1'b1);
    check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule